// File: doc/BRIEF.md
# Split-Permission Direct-Mapped TLB

This block caches virtual-to-physical page translations that have already been granted by logic outside it. It is direct-mapped. Each index holds one shared physical page number and three separate tags: one for instruction fetch, one for load and one for store. A translation installed for one kind of access therefore serves only that kind. A single entry can never grant every access type at once unless each type has been refilled on its own for the same page.

A lookup presents a virtual address and an access kind. One cycle later the block returns hit or miss and, on a hit, the physical address. A refill port installs a translation for one access kind. At the indexed slot it invalidates every other kind's tag that names a different virtual page, and it overwrites the shared page number. A flush input invalidates every tag in all three banks. Page table walking, permission checks and memory access all happen elsewhere.

Top module: `split_tlb`

## Requirements
- R1: After synchronous reset, `rs_valid` is low and every lookup misses until a refill installs a translation.
- R2: Every lookup accepted with `lk_valid` high produces exactly one result with `rs_valid` high on the next clock edge. `rs_valid` is low in all other cycles.
- R3: A lookup hits only when the tag of the requested kind at the indexed slot equals the virtual page number (`lk_vaddr[38:12]`). On a hit, `rs_paddr` is the stored page number followed by the 12-bit page offset. On a miss, `rs_paddr` is zero.
- R4: The slot index is the virtual page number modulo 64, which is its low 6 bits. The stored tag is the full page number, so two pages that share an index do not alias.
- R5: A refill writes the requesting kind's tag and the slot's shared page number. Another kind's tag at that slot that already names the same page stays valid and returns the new page number.
- R6: A refill invalidates, at its slot, every other kind's tag that names a different virtual page.
- R7: A refill leaves every other slot unchanged.
- R8: A flush invalidates all tags in all three banks. When a flush and a refill come in the same cycle, the flush wins and nothing is installed.
- R9: A lookup issued in the same cycle as a refill or flush sees the contents from before that cycle.
- R10: Kind encoding is 0 = fetch, 1 = load, 2 = store, 3 = none. A lookup of kind 3 always misses. A refill of kind 3 is ignored.
- R11: The invalid tag value is distinct from every page number, so the all-ones page number can be cached and hit like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_kind | input | 2 | Lookup access kind |
| lk_vaddr | input | 39 | Lookup virtual address |
| rs_valid | output | 1 | Lookup result strobe, one cycle after the request |
| rs_hit | output | 1 | Lookup hit |
| rs_paddr | output | 32 | Physical address on a hit, zero on a miss |
| rf_valid | input | 1 | Refill strobe |
| rf_kind | input | 2 | Access kind being installed |
| rf_vpn | input | 27 | Virtual page number being installed |
| rf_ppn | input | 20 | Physical page number being installed |
| flush | input | 1 | Invalidate all entries |

## Verification
A lookup can fall in the same cycle as a refill or a flush, and a flush can fall in the same cycle as a refill. The bench drives a refill and a lookup to the same slot together, once where the refill creates a translation and once where it evicts one. In both cases it expects the pre-refill answer, then confirms the new state with a second lookup. It also pairs a flush with a refill, and a flush with a lookup of a live entry. In the first case it expects every kind to miss afterwards. In the second it expects the lookup to still hit and the next one to miss.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    localparam int NUM_KINDS = 3;

    function automatic logic kind_is_real(acc_kind_e k);
        return k != ACC_NONE;
    endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank
    import split_tlb_pkg::*;
#(
    parameter int        ENTRIES = 64,
    parameter int        VPN_W   = 27,
    parameter acc_kind_e MY_KIND = ACC_FETCH,
    localparam int       IDX_W   = $clog2(ENTRIES),
    localparam int       TAG_W   = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  acc_kind_e        wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);

    // Valid tags carry a zero top bit; all ones can never equal a real page.
    localparam logic [TAG_W-1:0] TAG_INVALID = '1;

    logic [TAG_W-1:0] tags [ENTRIES];
    logic [TAG_W-1:0] new_tag;

    assign new_tag = {1'b0, wr_vpn};

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= TAG_INVALID;
            end
        end else if (wr_en) begin
            if (wr_kind == MY_KIND) begin
                tags[wr_idx] <= new_tag;
            end else if (tags[wr_idx] != new_tag) begin
                tags[wr_idx] <= TAG_INVALID;
            end
        end
    end

    // Registered read: same-cycle writes are not visible.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tag <= TAG_INVALID;
        end else begin
            rd_tag <= tags[rd_idx];
        end
    end

endmodule

// File: rtl/tlb_ppn_store.sv
module tlb_ppn_store #(
    parameter int  ENTRIES = 64,
    parameter int  PPN_W   = 20,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);

    logic [PPN_W-1:0] ppns [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ppns[wr_idx] <= wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ppn <= '0;
        end else begin
            rd_ppn <= ppns[rd_idx];
        end
    end

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import split_tlb_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 27,
    parameter int PPN_W   = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lk_valid,
    input  logic [1:0]               lk_kind,
    input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
    output logic                     rs_valid,
    output logic                     rs_hit,
    output logic [PPN_W+OFF_W-1:0]   rs_paddr,
    input  logic                     rf_valid,
    input  logic [1:0]               rf_kind,
    input  logic [VPN_W-1:0]         rf_vpn,
    input  logic [PPN_W-1:0]         rf_ppn,
    input  logic                     flush
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = VPN_W + 1;

    typedef struct packed {
        logic             v;
        acc_kind_e        kind;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } stage_t;

    acc_kind_e        rf_kind_e;
    logic             rf_go;
    logic             ppn_we;
    logic [IDX_W-1:0] rf_idx;
    logic [IDX_W-1:0] lk_idx;
    stage_t           st_q;
    logic [TAG_W-1:0] bank_tag [NUM_KINDS];
    logic [TAG_W-1:0] sel_tag;
    logic [PPN_W-1:0] ppn_q;

    assign rf_kind_e = acc_kind_e'(rf_kind);
    assign rf_go     = rf_valid && kind_is_real(rf_kind_e);
    assign ppn_we    = rf_go && !flush;
    assign rf_idx    = rf_vpn[IDX_W-1:0];
    assign lk_idx    = lk_vaddr[OFF_W +: IDX_W];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        tlb_tag_bank #(
            .ENTRIES (ENTRIES),
            .VPN_W   (VPN_W),
            .MY_KIND (acc_kind_e'(k))
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_en   (rf_go),
            .wr_kind (rf_kind_e),
            .wr_idx  (rf_idx),
            .wr_vpn  (rf_vpn),
            .rd_idx  (lk_idx),
            .rd_tag  (bank_tag[k])
        );
    end

    tlb_ppn_store #(
        .ENTRIES (ENTRIES),
        .PPN_W   (PPN_W)
    ) u_ppn (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ppn_we),
        .wr_idx (rf_idx),
        .wr_ppn (rf_ppn),
        .rd_idx (lk_idx),
        .rd_ppn (ppn_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.v    <= lk_valid;
            st_q.kind <= acc_kind_e'(lk_kind);
            st_q.vpn  <= lk_vaddr[OFF_W +: VPN_W];
            st_q.off  <= lk_vaddr[OFF_W-1:0];
        end
    end

    always_comb begin
        unique case (st_q.kind)
            ACC_FETCH: sel_tag = bank_tag[0];
            ACC_LOAD:  sel_tag = bank_tag[1];
            ACC_STORE: sel_tag = bank_tag[2];
            default:   sel_tag = '1;
        endcase
    end

    assign rs_valid = st_q.v;
    assign rs_hit   = st_q.v && kind_is_real(st_q.kind)
                      && (sel_tag == {1'b0, st_q.vpn});
    assign rs_paddr = rs_hit ? {ppn_q, st_q.off} : '0;

endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [1:0]      lk_kind,
    input logic            rs_valid,
    input logic            rs_hit,
    input logic [PA_W-1:0] rs_paddr,
    input logic            flush
);

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cyc == 2'd0 |-> !rs_valid);

    // R2
    rs_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cyc >= 2'd1 |-> rs_valid == $past(lk_valid));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> rs_paddr == '0);

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> rs_valid);

    // R10
    none_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(lk_valid && lk_kind == 2'd3)) |-> !rs_hit);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(flush, 2) && $past(lk_valid)) |-> !rs_hit);

endmodule

bind split_tlb split_tlb_chk #(.PA_W(PPN_W + OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_kind  (lk_kind),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_paddr (rs_paddr),
    .flush    (flush)
);

// File: tb/split_tlb_tb.sv
module split_tlb_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_kind = 2'd0;
    logic [38:0] lk_vaddr = '0;
    logic        rs_valid;
    logic        rs_hit;
    logic [31:0] rs_paddr;
    logic        rf_valid = 1'b0;
    logic [1:0]  rf_kind = 2'd0;
    logic [26:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        string       req;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;

    always #2.5 clk = ~clk;

    split_tlb u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_kind(lk_kind),
        .lk_vaddr(lk_vaddr), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_paddr(rs_paddr), .rf_valid(rf_valid), .rf_kind(rf_kind),
        .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .flush(flush)
    );

    localparam logic [1:0] KF = 2'd0, KL = 2'd1, KS = 2'd2, KN = 2'd3;

    // Monitor: pops expected results as the design produces them.
    always @(negedge clk) begin
        if (!rst && rs_valid) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R2: unexpected result hit=%0b pa=%h expected no result",
                         rs_hit, rs_paddr);
            end else begin
                mon_e = q.pop_front();
                if (rs_hit !== mon_e.hit || rs_paddr !== mon_e.pa) begin
                    failures++;
                    $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h",
                             mon_e.req, rs_hit, rs_paddr, mon_e.hit, mon_e.pa);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        lk_valid = 1'b0;
        rf_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic set_lk(input logic [1:0] k, input logic [26:0] vpn,
                          input logic [11:0] off, input logic hit,
                          input logic [19:0] ppn, input string req);
        exp_t e;
        e.hit = hit;
        e.pa  = hit ? {ppn, off} : 32'd0;
        e.req = req;
        q.push_back(e);
        lk_valid = 1'b1;
        lk_kind  = k;
        lk_vaddr = {vpn, off};
    endtask

    task automatic set_rf(input logic [1:0] k, input logic [26:0] vpn,
                          input logic [19:0] ppn);
        rf_valid = 1'b1;
        rf_kind  = k;
        rf_vpn   = vpn;
        rf_ppn   = ppn;
    endtask

    task automatic lookup(input logic [1:0] k, input logic [26:0] vpn,
                          input logic [11:0] off, input logic hit,
                          input logic [19:0] ppn, input string req);
        set_lk(k, vpn, off, hit, ppn, req);
        step();
    endtask

    task automatic refill(input logic [1:0] k, input logic [26:0] vpn,
                          input logic [19:0] ppn);
        set_rf(k, vpn, ppn);
        step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rs_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: rs_valid=%0b expected 0", rs_valid);
        end
        lookup(KF, 27'h5, 12'h0, 1'b0, 20'h0, "R1 miss after reset");

        // R3 R5: load refill serves load only
        refill(KL, 27'h105, 20'hABCDE);
        lookup(KL, 27'h105, 12'h123, 1'b1, 20'hABCDE, "R3 load hit");
        lookup(KF, 27'h105, 12'h0, 1'b0, 20'h0, "R5 fetch not granted");
        lookup(KS, 27'h105, 12'h0, 1'b0, 20'h0, "R5 store not granted");

        // R5: second kind same page keeps load valid, shared ppn
        refill(KF, 27'h105, 20'h11111);
        lookup(KF, 27'h105, 12'hFFF, 1'b1, 20'h11111, "R5 fetch hit");
        lookup(KL, 27'h105, 12'h001, 1'b1, 20'h11111, "R5 load kept, shared ppn");

        // R4: alias at same index misses
        lookup(KL, 27'h145, 12'h0, 1'b0, 20'h0, "R4 alias miss");

        // R6: store refill of other page evicts fetch and load
        refill(KS, 27'h145, 20'h22222);
        lookup(KS, 27'h145, 12'h456, 1'b1, 20'h22222, "R6 store hit");
        lookup(KL, 27'h105, 12'h0, 1'b0, 20'h0, "R6 load evicted");
        lookup(KF, 27'h105, 12'h0, 1'b0, 20'h0, "R6 fetch evicted");

        // R7: other slots untouched
        refill(KL, 27'h7, 20'h33333);
        refill(KF, 27'h8, 20'h44444);
        lookup(KL, 27'h7, 12'h010, 1'b1, 20'h33333, "R7 load slot 7");
        lookup(KF, 27'h8, 12'h020, 1'b1, 20'h44444, "R7 fetch slot 8");
        lookup(KS, 27'h145, 12'h030, 1'b1, 20'h22222, "R7 store slot 5 kept");

        // R9: same-cycle refill and lookup see old contents
        set_rf(KL, 27'h9, 20'h00005);
        set_lk(KL, 27'h9, 12'h0, 1'b0, 20'h0, "R9 refill same cycle miss");
        step();
        lookup(KL, 27'h9, 12'h0AA, 1'b1, 20'h00005, "R9 hit after refill");
        set_rf(KL, 27'h49, 20'h66666);
        set_lk(KL, 27'h9, 12'h0BB, 1'b1, 20'h00005, "R9 evict same cycle old hit");
        step();
        lookup(KL, 27'h9, 12'h0, 1'b0, 20'h0, "R9 evicted next cycle");
        lookup(KL, 27'h49, 12'h0CC, 1'b1, 20'h66666, "R9 new page hit");

        // R10: kind none
        refill(KN, 27'h7, 20'h77777);
        lookup(KL, 27'h7, 12'h0, 1'b1, 20'h33333, "R10 none refill ignored");
        lookup(KN, 27'h7, 12'h0, 1'b0, 20'h0, "R10 none lookup miss");

        // R11: all-ones page
        lookup(KL, 27'h7FFFFFF, 12'h0, 1'b0, 20'h0, "R11 all-ones miss when empty");
        refill(KL, 27'h7FFFFFF, 20'h88888);
        lookup(KL, 27'h7FFFFFF, 12'hABC, 1'b1, 20'h88888, "R11 all-ones hit");

        // R8: flush beats refill
        flush = 1'b1;
        set_rf(KF, 27'hA, 20'h00001);
        step();
        lookup(KF, 27'hA, 12'h0, 1'b0, 20'h0, "R8 refill lost to flush");
        lookup(KL, 27'h7, 12'h0, 1'b0, 20'h0, "R8 load flushed");
        lookup(KS, 27'h145, 12'h0, 1'b0, 20'h0, "R8 store flushed");
        lookup(KL, 27'h7FFFFFF, 12'h0, 1'b0, 20'h0, "R8 all-ones flushed");

        // R9 R8: flush with lookup in same cycle
        refill(KL, 27'hB, 20'h00002);
        flush = 1'b1;
        set_lk(KL, 27'hB, 12'h011, 1'b1, 20'h00002, "R9 flush same cycle old hit");
        step();
        lookup(KL, 27'hB, 12'h0, 1'b0, 20'h0, "R8 miss after flush");

        repeat (3) step();
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R2: %0d results missing expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, pending=%0d expected 0", q.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule